// File: doc/BRIEF.md
# Privileged Control and Debug Register Unit

This block holds the privileged control registers and debug registers of a 32-bit processor core. The instruction decoder sends it move-to and move-from requests. Each request names a register class (control or debug), a 3-bit register number, a direction, write data and the current privilege level. The block either completes the transfer or reports a fault. There are two fault codes: general-protection and undefined-opcode.

The checks run in a fixed order, and the first one that fails sets the fault:

1. Privilege level must be zero.
2. For control registers: the register number must exist. For debug registers: the general-detect lock must be clear.
3. For a write to control register 0: the new value must be a legal combination of bits.

Debug numbers 6 and 7 share storage with numbers 4 and 5. Number 4/6 is the status register and number 5/7 is the debug control register. Each of these two has reserved bits that are forced on every write. Every request completes one clock after it is presented. A done pulse then carries either read data or a fault code.

Top module: `priv_reg_unit`

## Requirements
- R1: A request presented with `req_valid` high is answered by a single-cycle `done` pulse on the next clock edge. `done` stays low in cycles that follow no request.
- R2: A request at a privilege level other than zero completes with fault code 2'b01 (general-protection) and changes no register. This check takes precedence over the existence check and the general-detect check.
- R3: A control-class request for number 1, 4, 5, 6 or 7 completes with fault code 2'b10 (undefined-opcode) and changes no register.
- R4: A write to control register 0 whose value has bit 31 (paging) set and bit 0 (protection enable) clear faults with code 2'b01 and leaves control register 0 unchanged.
- R5: A write to control register 0 whose value has bit 29 (not-write-through) set and bit 30 (cache disable) clear faults with code 2'b01 and leaves control register 0 unchanged.
- R6: Control registers 0, 2 and 3 are independent 32-bit registers. A successful read returns the last value successfully written to that register.
- R7: Debug numbers 6 and 7 address the same storage as numbers 4 and 5. A write through either number is visible through the other. Debug numbers 0 to 3 are independent registers.
- R8: While bit 13 (general detect) of debug register 5/7 is set, every debug-class request faults with code 2'b01 and changes nothing.
- R9: On a write to debug register 4/6, bits 4 to 11 and 16 to 31 are stored as one, whatever the write data.
- R10: On a write to debug register 5/7, bits 11, 12, 14 and 15 are stored as zero, whatever the write data.
- R11: After reset, `done` is low, `fault_code` is 2'b00, and every register reads zero, except debug register 4/6, which reads 32'hFFFF0FF0.
- R12: `rd_data` is zero in the done cycle of any faulting request and of any successful write. Fault code 2'b00 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move into register, 0 = move out |
| req_dbg | input | 1 | 1 = debug class, 0 = control class |
| req_num | input | 3 | Architectural register number |
| req_wdata | input | 32 | Value for a write |
| req_cpl | input | 2 | Current privilege level |
| done | output | 1 | Completion pulse, one cycle after the request |
| rd_data | output | 32 | Read result, valid with `done` |
| fault_code | output | 2 | 00 none, 01 general-protection, 10 undefined-opcode |

## Verification
The embedded assertions check the following on every cycle:
- the done timing;
- the general-protection fault for non-zero privilege, and that no register moves on such a request;
- the undefined-opcode fault for missing control numbers;
- the general-detect lockout;
- zero read data on faults;
- that the stored control register 0 never holds an illegal combination;
- that the reserved bits of the debug status and debug control registers always hold their forced values.

Only the bench scenarios can show the value-carrying behaviour: that a rejected control register 0 write keeps the old value, that the aliased debug numbers really share storage, and that the control registers 0, 2 and 3 stay separate. These are checked against a behavioural model over directed and pseudo-random request streams.

// File: rtl/priv_reg_pkg.sv
package priv_reg_pkg;

  localparam int REG_W   = 32;
  localparam int NUM_W   = 3;
  localparam int CPL_W   = 2;

  // control register 0 bit positions
  localparam int CR0_PE  = 0;
  localparam int CR0_NW  = 29;
  localparam int CR0_CD  = 30;
  localparam int CR0_PG  = 31;

  // debug register bit positions and masks
  localparam int                DBG_GD_BIT   = 13;
  localparam logic [REG_W-1:0]  STAT_ONES    = 32'hFFFF_0FF0;
  localparam logic [REG_W-1:0]  CTL_ZEROS    = 32'h0000_D800;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_UD   = 2'b10
  } flt_e;

  // a control register 0 value is acceptable unless paging lacks protection
  // or not-write-through lacks cache-disable
  function automatic logic cr0_legal(input logic [REG_W-1:0] v);
    logic bad_pg, bad_nw;
    bad_pg = v[CR0_PG] & ~v[CR0_PE];
    bad_nw = v[CR0_NW] & ~v[CR0_CD];
    return ~(bad_pg | bad_nw);
  endfunction

  // only numbers 0, 2 and 3 are present in the control class
  function automatic logic cr_exists(input logic [NUM_W-1:0] n);
    return (n == 3'd0) || (n == 3'd2) || (n == 3'd3);
  endfunction

  // 0 -> slot 0, 2 -> slot 1, 3 -> slot 2
  function automatic logic [1:0] cr_slot(input logic [NUM_W-1:0] n);
    return (n[1:0] == 2'd0) ? 2'd0 : (n[1:0] - 2'd1);
  endfunction

  // 6 and 7 fold onto 4 and 5
  function automatic logic [2:0] dr_slot(input logic [NUM_W-1:0] n);
    return (n[2] && n[1]) ? {2'b10, n[0]} : n;
  endfunction

endpackage

// File: rtl/priv_req_check.sv
module priv_req_check
  import priv_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             write,
  input  logic             dbg,
  input  logic [NUM_W-1:0] num,
  input  logic [REG_W-1:0] wdata,
  input  logic [CPL_W-1:0] cpl,
  input  logic             gd_lock,
  output flt_e             code,
  output logic             cr_we,
  output logic             dr_we
);

  logic priv_bad, ex_bad, gd_bad, val_bad;

  assign priv_bad = (cpl != '0);
  assign ex_bad   = !dbg && !cr_exists(num);
  assign gd_bad   = dbg && gd_lock;
  assign val_bad  = !dbg && write && (num == 3'd0) && !cr0_legal(wdata);

  // fixed order: privilege, then existence / lock, then value
  always_comb begin
    if (priv_bad)      code = FLT_GP;
    else if (ex_bad)   code = FLT_UD;
    else if (gd_bad)   code = FLT_GP;
    else if (val_bad)  code = FLT_GP;
    else               code = FLT_NONE;
  end

  assign cr_we = valid && write && !dbg && (code == FLT_NONE);
  assign dr_we = valid && write &&  dbg && (code == FLT_NONE);

  // R8
  gd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && dbg && gd_lock |-> code == FLT_GP && !dr_we);

  // R2
  priv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (cpl != '0) |-> code == FLT_GP && !cr_we && !dr_we);

endmodule

// File: rtl/priv_ctrl_bank.sv
module priv_ctrl_bank
  import priv_reg_pkg::*;
#(
  parameter int SLOTS  = 3,
  localparam int SEL_W = $clog2(SLOTS)
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [SEL_W-1:0]            sel,
  input  logic [REG_W-1:0]            wdata,
  output logic [SLOTS-1:0][REG_W-1:0] q
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[i] <= '0;
      else if (we && (sel == SEL_W'(i)))   q[i] <= wdata;
    end
  end

  // R4 R5
  cr0_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr0_legal(q[0]));

endmodule

// File: rtl/priv_dbg_bank.sv
module priv_dbg_bank
  import priv_reg_pkg::*;
#(
  parameter int SLOTS    = 6,
  parameter int STAT_IDX = 4,
  parameter int CTL_IDX  = 5,
  localparam int SEL_W   = $clog2(SLOTS)
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [SEL_W-1:0]            sel,
  input  logic [REG_W-1:0]            wdata,
  output logic [SLOTS-1:0][REG_W-1:0] q,
  output logic                        gd_lock
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [REG_W-1:0] fixed;
    logic [REG_W-1:0] rst_val;
    if (i == STAT_IDX) begin : g_stat
      assign fixed   = wdata | STAT_ONES;
      assign rst_val = STAT_ONES;
    end else if (i == CTL_IDX) begin : g_ctl
      assign fixed   = wdata & ~CTL_ZEROS;
      assign rst_val = '0;
    end else begin : g_plain
      assign fixed   = wdata;
      assign rst_val = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[i] <= rst_val;
      else if (we && (sel == SEL_W'(i)))   q[i] <= fixed;
    end
  end

  assign gd_lock = q[CTL_IDX][DBG_GD_BIT];

  // R9
  stat_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[STAT_IDX] & STAT_ONES) == STAT_ONES);

  // R10
  ctl_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[CTL_IDX] & CTL_ZEROS) == '0);

endmodule

// File: rtl/priv_reg_unit.sv
module priv_reg_unit
  import priv_reg_pkg::*;
#(
  parameter int CR_SLOTS = 3,
  parameter int DR_SLOTS = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dbg,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic [CPL_W-1:0]  req_cpl,
  output logic              done,
  output logic [REG_W-1:0]  rd_data,
  output logic [1:0]        fault_code
);

  localparam int CR_SEL_W = $clog2(CR_SLOTS);
  localparam int DR_SEL_W = $clog2(DR_SLOTS);

  flt_e                           chk_code;
  logic                           cr_we, dr_we, gd_lock;
  logic [CR_SLOTS-1:0][REG_W-1:0] cr_q;
  logic [DR_SLOTS-1:0][REG_W-1:0] dr_q;
  logic [CR_SEL_W-1:0]            cr_sel;
  logic [DR_SEL_W-1:0]            dr_sel;
  logic [REG_W-1:0]               rd_sel;
  logic                           rd_ok;

  assign cr_sel = CR_SEL_W'(cr_slot(req_num));
  assign dr_sel = DR_SEL_W'(dr_slot(req_num));

  priv_req_check u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .write   (req_write),
    .dbg     (req_dbg),
    .num     (req_num),
    .wdata   (req_wdata),
    .cpl     (req_cpl),
    .gd_lock (gd_lock),
    .code    (chk_code),
    .cr_we   (cr_we),
    .dr_we   (dr_we)
  );

  priv_ctrl_bank #(.SLOTS(CR_SLOTS)) u_cr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cr_we),
    .sel   (cr_sel),
    .wdata (req_wdata),
    .q     (cr_q)
  );

  priv_dbg_bank #(.SLOTS(DR_SLOTS)) u_dr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (dr_we),
    .sel     (dr_sel),
    .wdata   (req_wdata),
    .q       (dr_q),
    .gd_lock (gd_lock)
  );

  assign rd_ok  = req_valid && !req_write && (chk_code == FLT_NONE);

  always_comb begin
    rd_sel = '0;
    if (req_dbg) begin
      for (int i = 0; i < DR_SLOTS; i++)
        if (dr_sel == DR_SEL_W'(i)) rd_sel = dr_q[i];
    end else begin
      for (int i = 0; i < CR_SLOTS; i++)
        if (cr_sel == CR_SEL_W'(i)) rd_sel = cr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault_code <= FLT_NONE;
      rd_data    <= '0;
    end else begin
      done       <= req_valid;
      fault_code <= req_valid ? chk_code : FLT_NONE;
      rd_data    <= rd_ok ? rd_sel : '0;
    end
  end

  // R1
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);

  // R2
  priv_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_cpl != '0) |=> fault_code == FLT_GP && $stable(cr_q) && $stable(dr_q));

  // R3
  absent_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_dbg && (req_cpl == '0) && !cr_exists(req_num)
      |=> fault_code == FLT_UD && $stable(cr_q));

  // R12
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault_code != FLT_NONE) |-> rd_data == '0);

endmodule

// File: tb/test_priv_reg_unit.sv
module test_priv_reg_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_dbg;
  logic [2:0]  req_num;
  logic [31:0] req_wdata;
  logic [1:0]  req_cpl;
  logic        done;
  logic [31:0] rd_data;
  logic [1:0]  fault_code;

  int vectors = 0;
  int misses  = 0;

  // behavioural model, indexed by architectural number
  logic [31:0] crm [8];
  logic [31:0] drm [8];

  always #10 clk = ~clk;

  priv_reg_unit i_priv_reg_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_dbg    (req_dbg),
    .req_num    (req_num),
    .req_wdata  (req_wdata),
    .req_cpl    (req_cpl),
    .done       (done),
    .rd_data    (rd_data),
    .fault_code (fault_code)
  );

  task automatic cmp(input string tag, input logic e_done, input logic [1:0] e_code,
                     input logic [31:0] e_rd);
    vectors++;
    if (done !== e_done || fault_code !== e_code || rd_data !== e_rd) begin
      misses++;
      $display("FAIL %s: got done=%b code=%b rd=%h, expected done=%b code=%b rd=%h",
               tag, done, fault_code, rd_data, e_done, e_code, e_rd);
    end
  endtask

  // one clock: drive request, predict, compare after the edge
  task automatic step(input bit v, input bit w, input bit d, input int n,
                      input logic [31:0] wd, input int cpl, input string tag);
    logic [1:0]  e_code;
    logic [31:0] e_rd;
    logic [31:0] val;
    req_valid = v; req_write = w; req_dbg = d;
    req_num = 3'(n); req_wdata = wd; req_cpl = 2'(cpl);
    e_code = 2'b00;
    e_rd   = 32'h0;
    if (v) begin
      if (cpl != 0)                                     e_code = 2'b01;
      else if (!d && (n == 1 || n > 3))                 e_code = 2'b10;
      else if (d && drm[7][13])                         e_code = 2'b01;
      else if (!d && w && n == 0 &&
               ((wd[31] && !wd[0]) || (wd[29] && !wd[30]))) e_code = 2'b01;
      if (e_code == 2'b00) begin
        if (!w) e_rd = d ? drm[n] : crm[n];
        else if (!d) crm[n] = wd;
        else begin
          val = wd;
          if (n == 4 || n == 6) begin
            val = val | 32'hFFFF0FF0; drm[4] = val; drm[6] = val;
          end else if (n == 5 || n == 7) begin
            val = val & ~32'h0000D800; drm[5] = val; drm[7] = val;
          end else drm[n] = val;
        end
      end
    end
    @(negedge clk);
    cmp(tag, v, e_code, e_rd);
  endtask

  initial begin
    #(20 * 100000);
    misses++;
    $display("FAIL R1: watchdog expired, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin crm[i] = '0; drm[i] = '0; end
    drm[4] = 32'hFFFF0FF0; drm[6] = 32'hFFFF0FF0;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_dbg = 0;
    req_num = 0; req_wdata = 0; req_cpl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp("R11 reset outputs", 1'b0, 2'b00, 32'h0);

    // R11 reset contents
    step(1,0,1,6,0,0,"R11 status reset");
    step(1,0,1,4,0,0,"R11 status reset alias");
    step(1,0,0,0,0,0,"R11 cr0 reset");
    step(1,0,1,7,0,0,"R11 dbg ctl reset");
    step(0,0,0,0,0,0,"R1 idle");

    // R6 distinct control registers
    step(1,1,0,0,32'hE000_0001,0,"R6 cr0 legal write");
    step(1,1,0,2,32'h1234_5678,0,"R6 cr2 write");
    step(1,1,0,3,32'h9ABC_DEF0,0,"R6 cr3 write");
    step(1,0,0,0,0,0,"R6 cr0 read");
    step(1,0,0,2,0,0,"R6 cr2 read");
    step(1,0,0,3,0,0,"R6 cr3 read");

    // R4 R5 illegal cr0 writes discarded
    step(1,1,0,0,32'h8000_0000,0,"R4 pg without pe");
    step(1,0,0,0,0,0,"R4 cr0 kept");
    step(1,1,0,0,32'h2000_0001,0,"R5 nw without cd");
    step(1,0,0,0,0,0,"R5 cr0 kept");

    // R2 privilege, including precedence over absent number
    step(1,1,0,0,32'h0000_0001,3,"R2 cpl3 write");
    step(1,0,0,0,0,0,"R2 cr0 unchanged");
    step(1,0,0,1,0,1,"R2 precedence over ud");
    step(1,1,1,0,32'hAAAA_AAAA,2,"R2 debug cpl2");
    step(1,0,1,0,0,0,"R2 dr0 unchanged");

    // R3 absent control numbers
    for (int n = 4; n < 8; n++) step(1,0,0,n,0,0,"R3 absent read");
    step(1,1,0,1,32'hFFFF_FFFF,0,"R3 absent write");
    step(1,0,0,3,0,0,"R3 cr3 unchanged");

    // R7 R9 R10 aliases and reserved bits; R12 write rd zero
    step(1,1,1,4,32'h0000_0000,0,"R9 status write");
    step(1,0,1,6,0,0,"R7 R9 status via alias");
    step(1,1,1,7,32'hFFFF_DFFF,0,"R10 ctl write");
    step(1,0,1,5,0,0,"R7 R10 ctl via alias");
    for (int n = 0; n < 4; n++) step(1,1,1,n,32'h1111_0000 * n + 32'h55,0,"R7 dr write");
    for (int n = 0; n < 4; n++) step(1,0,1,n,0,0,"R7 dr read");

    // pseudo-random stream, general detect kept clear
    for (int k = 0; k < 300; k++) begin
      automatic bit d = 1'($urandom);
      automatic int n = int'($urandom % 8);
      automatic bit w = 1'($urandom);
      automatic logic [31:0] wd = $urandom;
      automatic int cpl = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      if (d && (n == 5 || n == 7)) wd[13] = 1'b0;
      step(1'($urandom % 5 != 0), w, d, n, wd, cpl, "R6 R7 random");
    end

    // R8 general detect lock
    step(1,1,1,5,32'h0000_2000,0,"R8 set gd");
    step(1,0,1,0,0,0,"R8 read locked");
    step(1,1,1,2,32'hDEAD_BEEF,0,"R8 write locked");
    step(1,0,1,7,0,0,"R8 ctl read locked");
    step(1,0,0,2,0,0,"R8 control class unaffected");
    step(1,0,1,3,0,2,"R2 R8 cpl fault");
    step(0,0,0,0,0,0,"R1 idle end");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule